// File: doc/BRIEF.md
# Gated Period Counter

A 16-bit up-counter that advances on a tick enable only while its gate condition is true. The gate comes from one of two places. The first is an asynchronous pin, which is resynchronized before use. The second is the single-cycle rollover pulse of a neighbouring 8-bit timer, which is already synchronous to the clock.

A polarity control picks which gate level counts as active. A toggle stage can be switched in. It flips on every active edge of the gate, so the counter gathers ticks across one complete gate period instead of only the active phase. Turning off the toggle stage, or the timer itself, forces the toggle state to zero and keeps it there. Software can therefore arm a measurement with a known starting phase.

The count can be preset through a load strobe. A rollover from all ones to zero raises a sticky flag, which software clears with a strobe.

Top module: `gtmr_gated_counter`

## Requirements
- R1: Apart from a load, the count grows by exactly one at a clock edge where `run_en`, `tick_en` and either `!gate_en` or `gate_level` are all 1. At every other edge the count is unchanged.
- R2: With `toggle_mode`=0, `gate_level` equals the selected gate source when `gate_pol`=1 and its inverse when `gate_pol`=0. The active edge is the rising edge of this polarity-adjusted signal.
- R3: `gate_sel`=0 selects `gate_pin` through a two-flop synchronizer, so a pin change shows on `gate_level` after two clock edges. `gate_sel`=1 selects `tmr_ovf_pulse` with no added delay.
- R4: With `toggle_mode`=1, `gate_level` is a toggle state that inverts at each active edge. Two active edges P cycles apart with ticks always on leave exactly P added to the count.
- R5: While `toggle_mode`=0, the toggle state is cleared at every edge. Re-enabling toggle mode with no active edge present shows `gate_level`=0.
- R6: While `run_en`=0, the toggle state is cleared and held at 0 even if active edges arrive, and the count does not advance.
- R7: An increment from 16'hFFFF gives 16'h0000 and sets `ovf_flag`. The flag stays set until an `ovf_clr` cycle. If a set and a clear fall in the same cycle, the set wins.
- R8: When `load_stb`=1, the count takes `load_val` at the next edge, overriding any increment in that cycle.
- R9: After reset, the count, `ovf_flag`, the toggle state and the synchronizer are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer on |
| tick_en | input | 1 | Count enable for this cycle |
| gate_en | input | 1 | 1: count only while gate active; 0: free run |
| gate_pol | input | 1 | 1: active high; 0: active low |
| toggle_mode | input | 1 | 1: full-period toggle stage in use |
| gate_sel | input | 1 | 0: pin; 1: neighbour timer rollover pulse |
| gate_pin | input | 1 | Asynchronous gate pin |
| tmr_ovf_pulse | input | 1 | Synchronous rollover pulse of 8-bit timer |
| load_stb | input | 1 | Load strobe |
| load_val | input | 16 | Value to load |
| ovf_clr | input | 1 | Clear strobe for overflow flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky rollover flag |
| gate_level | output | 1 | Effective gate level |

## Verification
The hardest state to reach from the ports is a toggle state that is set internally while the visible `gate_level` shows something else. This happens when toggle mode is briefly switched off, or the timer is stopped between gate edges. To cover it, the stimulus sets the toggle state with one pulse from the rollover source. It then drops `toggle_mode` or `run_en` for one edge and re-enables it with no edge present. `gate_level` must then read 0. Period measurement is checked by spacing two pulses a known number of cycles apart and comparing the count against that spacing.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
   typedef enum logic {
      GSRC_PIN = 1'b0,
      GSRC_TMR = 1'b1
   } gate_src_e;

   localparam int unsigned CNT_W_DEF  = 16;
   localparam int unsigned SYNC_N_DEF = 2;
endpackage

// File: rtl/gtmr_sync.sv
module gtmr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gtmr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gtmr_gate_path.sv
module gtmr_gate_path
   import gtmr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_sync,
   input  logic      tmr_pulse,
   input  gate_src_e src,
   input  logic      pol,
   input  logic      toggle_mode,
   input  logic      run_en,
   output logic      gate_eff
);
   logic raw_gate;
   logic adj_gate;
   logic adj_prev;
   logic act_edge;
   logic tog_q;

   always_comb begin
      unique case (src)
         GSRC_PIN: raw_gate = pin_sync;
         default:  raw_gate = tmr_pulse;
      endcase
   end

   assign adj_gate = pol ? raw_gate : ~raw_gate;
   assign act_edge = adj_gate & ~adj_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) adj_prev <= 1'b0;
      else        adj_prev <= adj_gate;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      tog_q <= 1'b0;
      else if (!toggle_mode || !run_en) tog_q <= 1'b0;
      else if (act_edge)               tog_q <= ~tog_q;
   end

   assign gate_eff = toggle_mode ? tog_q : adj_gate;
endmodule

// File: rtl/gtmr_count_core.sv
module gtmr_count_core #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_en,
   input  logic         tick_en,
   input  logic         gate_en,
   input  logic         gate_eff,
   input  logic         load_stb,
   input  logic [W-1:0] load_val,
   input  logic         ovf_clr,
   output logic [W-1:0] count,
   output logic         ovf_flag
);
   if (W < 2) begin : g_bad_width
      $error("gtmr_count_core: W must be at least 2");
   end

   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   logic step;
   logic wrap;

   assign step = run_en & tick_en & (~gate_en | gate_eff) & ~load_stb;
   assign wrap = step & (count == ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (load_stb) count <= load_val;
      else if (step)     count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (wrap)    ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end
endmodule

// File: rtl/gtmr_gated_counter.sv
module gtmr_gated_counter
   import gtmr_pkg::*;
#(
   parameter int unsigned CNT_W  = CNT_W_DEF,
   parameter int unsigned SYNC_N = SYNC_N_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             tick_en,
   input  logic             gate_en,
   input  logic             gate_pol,
   input  logic             toggle_mode,
   input  logic             gate_sel,
   input  logic             gate_pin,
   input  logic             tmr_ovf_pulse,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] load_val,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             gate_level
);
   logic      pin_s;
   gate_src_e src;

   assign src = gate_src_e'(gate_sel);

   gtmr_sync #(.STAGES(SYNC_N)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gate_pin),
      .q     (pin_s)
   );

   gtmr_gate_path u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_sync    (pin_s),
      .tmr_pulse   (tmr_ovf_pulse),
      .src         (src),
      .pol         (gate_pol),
      .toggle_mode (toggle_mode),
      .run_en      (run_en),
      .gate_eff    (gate_level)
   );

   gtmr_count_core #(.W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .tick_en  (tick_en),
      .gate_en  (gate_en),
      .gate_eff (gate_level),
      .load_stb (load_stb),
      .load_val (load_val),
      .ovf_clr  (ovf_clr),
      .count    (count),
      .ovf_flag (ovf_flag)
   );
endmodule

// File: rtl/gtmr_gated_counter_chk.sv
module gtmr_gated_counter_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             tick_en,
   input logic             gate_en,
   input logic             toggle_mode,
   input logic             load_stb,
   input logic [CNT_W-1:0] load_val,
   input logic             ovf_clr,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             gate_level
);
   logic adv;
   assign adv = !load_stb && run_en && tick_en && (!gate_en || gate_level);

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> count == $past(count) + 1'b1);  // R1
   AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_stb && !tick_en) |=> $stable(count));  // R1
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> count == $past(load_val));  // R8
   AST_TOG_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !toggle_mode |=> (!toggle_mode || !gate_level));  // R5
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!toggle_mode || !gate_level));  // R6
   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !load_stb) |=> $stable(count));  // R6
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && count == {CNT_W{1'b1}}) |=> (ovf_flag && count == '0));  // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);  // R7
endmodule

bind gtmr_gated_counter gtmr_gated_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_en      (run_en),
   .tick_en     (tick_en),
   .gate_en     (gate_en),
   .toggle_mode (toggle_mode),
   .load_stb    (load_stb),
   .load_val    (load_val),
   .ovf_clr     (ovf_clr),
   .count       (count),
   .ovf_flag    (ovf_flag),
   .gate_level  (gate_level)
);

// File: tb/tb_gtmr_gated_counter.sv
`timescale 1ns/1ps
module tb_gtmr_gated_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0, tick_en = 1'b0, gate_en = 1'b0, gate_pol = 1'b1;
   logic        toggle_mode = 1'b0, gate_sel = 1'b0, gate_pin = 1'b0, tmr_ovf_pulse = 1'b0;
   logic        load_stb = 1'b0, ovf_clr = 1'b0;
   logic [15:0] load_val = '0;
   logic [15:0] count;
   logic        ovf_flag, gate_level;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gtmr_gated_counter dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_en(tick_en),
      .gate_en(gate_en), .gate_pol(gate_pol), .toggle_mode(toggle_mode),
      .gate_sel(gate_sel), .gate_pin(gate_pin), .tmr_ovf_pulse(tmr_ovf_pulse),
      .load_stb(load_stb), .load_val(load_val), .ovf_clr(ovf_clr),
      .count(count), .ovf_flag(ovf_flag), .gate_level(gate_level)
   );

   // stimulus fields: {run_en, gate_en, gate_pol, gate source level, tick_en}
   localparam logic [4:0] VEC [10] = '{
      5'b10101, 5'b11101, 5'b11111, 5'b11110, 5'b11001,
      5'b11011, 5'b00111, 5'b11111, 5'b10011, 5'b01111
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_load(input logic [15:0] v);
      load_stb = 1'b1; load_val = v;
      edges(1);
      load_stb = 1'b0;
   endtask

   task automatic pulse();
      tmr_ovf_pulse = 1'b1;
      edges(1);
      tmr_ovf_pulse = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp_cnt;
      logic        lvl;
      edges(2);
      // R9 reset state
      chk("R9 count", count, 16'h0);
      chk("R9 ovf", ovf_flag, 1'b0);
      chk("R9 level", gate_level, 1'b0);
      rst_n = 1'b1;
      edges(1);

      // R3 two-flop synchronizer latency on pin source
      run_en = 1'b1; tick_en = 1'b1; gate_en = 1'b1; gate_pol = 1'b1; gate_sel = 1'b0;
      load_stb = 1'b1; load_val = 16'h0; gate_pin = 1'b1;
      edges(1);
      load_stb = 1'b0;
      chk("R3 level after 1 edge", gate_level, 1'b0);
      edges(1);
      chk("R3 level after 2 edges", gate_level, 1'b1);
      chk("R3 count before gate", count, 16'h0);
      edges(1);
      chk("R3 count after gate", count, 16'h1);
      gate_pin = 1'b0; run_en = 1'b0;
      edges(3);

      // R1 R2 table walk using the timer pulse source as a level
      gate_sel = 1'b1;
      do_load(16'h0);
      exp_cnt = 16'h0;
      foreach (VEC[k]) begin
         run_en = VEC[k][4]; gate_en = VEC[k][3]; gate_pol = VEC[k][2];
         tmr_ovf_pulse = VEC[k][1]; tick_en = VEC[k][0];
         lvl = VEC[k][2] ? VEC[k][1] : ~VEC[k][1];
         #1;
         chk("R2 gate_level", gate_level, lvl);
         if (VEC[k][4] && VEC[k][0] && (!VEC[k][3] || lvl)) exp_cnt = exp_cnt + 16'h1;
         edges(1);
         chk("R1 count", count, exp_cnt);
      end
      tmr_ovf_pulse = 1'b0; gate_pol = 1'b1;

      // R4 period measurement: pulses 6 cycles apart
      run_en = 1'b1; tick_en = 1'b1; gate_en = 1'b1; toggle_mode = 1'b0;
      edges(1);
      toggle_mode = 1'b1;
      do_load(16'h0);
      pulse();
      chk("R4 level after first edge", gate_level, 1'b1);
      chk("R4 count at start", count, 16'h0);
      edges(5);
      pulse();
      chk("R4 period count", count, 16'h6);
      chk("R4 level after second edge", gate_level, 1'b0);
      edges(3);
      chk("R4 count holds", count, 16'h6);

      // R6 stopping the timer clears and holds the toggle state
      pulse();
      chk("R6 level set", gate_level, 1'b1);
      run_en = 1'b0;
      edges(1);
      chk("R6 level cleared", gate_level, 1'b0);
      edges(1);
      pulse();
      chk("R6 held clear", gate_level, 1'b0);
      run_en = 1'b1;
      edges(1);
      chk("R6 still clear after restart", gate_level, 1'b0);

      // R5 leaving toggle mode clears the toggle state
      pulse();
      chk("R5 level set", gate_level, 1'b1);
      toggle_mode = 1'b0;
      edges(1);
      toggle_mode = 1'b1;
      #1;
      chk("R5 cleared on re-enable", gate_level, 1'b0);
      toggle_mode = 1'b0;

      // R8 load beats increment
      gate_en = 1'b0; tick_en = 1'b1; run_en = 1'b1;
      do_load(16'h1234);
      chk("R8 load wins", count, 16'h1234);
      edges(1);
      chk("R8 count after load", count, 16'h1235);

      // R7 rollover and sticky flag
      tick_en = 1'b0;
      do_load(16'hFFFE);
      tick_en = 1'b1;
      edges(1);
      chk("R7 count FFFF", count, 16'hFFFF);
      chk("R7 no flag yet", ovf_flag, 1'b0);
      edges(1);
      chk("R7 wrap to 0", count, 16'h0);
      chk("R7 flag set", ovf_flag, 1'b1);
      tick_en = 1'b0;
      edges(2);
      chk("R7 flag sticky", ovf_flag, 1'b1);
      ovf_clr = 1'b1;
      edges(1);
      ovf_clr = 1'b0;
      chk("R7 flag cleared", ovf_flag, 1'b0);
      do_load(16'hFFFF);
      tick_en = 1'b1; ovf_clr = 1'b1;
      edges(1);
      tick_en = 1'b0; ovf_clr = 1'b0;
      chk("R7 set beats clear", ovf_flag, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule